// File: doc/BRIEF.md
# Digit-Serial Multiplier with Run-Time Word Length

This block multiplies two unsigned fixed-point operands using a datapath of fixed width whose operation length is chosen at run time. The multiplicand is captured in parallel, at the maximum width, when an operation starts. The multiplier operand then streams in one digit per transfer, least significant digit first. Each accepted input digit produces one product digit right away. Once the last input digit has been consumed, the upper half of the product is drained over as many further digit transfers.

The word length comes from a small mode register. Software-style writes to that register take effect at once while the block is idle. A write made during an operation is parked and applied when the operation finishes. The hardware stays the same for every word length. A shorter word only means fewer digit cycles, so a build can give up precision for throughput while it runs.

Both digit streams use valid/ready. While the multiplier digits are being fed, the two streams are locked together. An input digit is taken only when the consumer can take the product digit that it produces. So back-pressure on the output stalls the input, and an empty input stalls the output. During the drain phase the input stream is closed. Each upper product digit is then offered with valid held high, and it stays stable until it is accepted.

Top module: `dsmul_top`

## Requirements
- R1: After reset, busy_o, done_o, m_valid_o and s_ready_o are all low.
- R2: For word length W and operands A, B below 2^W, the block accepts the W/N digits of B least significant first. It emits 2W/N product digits least significant first, and these reassemble to exactly A*B. N is the digit width: 8 by default, 16 as the other build choice.
- R3: Word length coding on mode_i: 0 selects 16 bits, 1 selects 24 bits, and 2 or 3 select 32 bits. In a 16-bit-digit build, code 1 selects 32 bits.
- R4: An operation accepts exactly W/N input digits. After the last of them, s_ready_o stays low until the next start.
- R5: While input digits are being fed, s_ready_o equals m_ready_i and m_valid_o follows s_valid_i. During the drain phase, m_valid_o is high, and a digit that is not accepted stays unchanged in the next cycle.
- R6: A mode write (mode_we_i) while idle applies from the next start on. A mode write while busy does not change the running operation and takes effect for the operation after done.
- R7: done_o is a one-cycle pulse in the cycle after the final product digit is accepted. busy_o is low in that same cycle.
- R8: start_i is ignored while busy_o is high, and the running product is unaffected.
- R9: A start_i while idle raises busy_o in the next cycle and captures opa_i as the multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Word-length code (R3) |
| mode_we_i | input | 1 | Write strobe for mode_i |
| start_i | input | 1 | Begin an operation when idle |
| opa_i | input | MAX_W | Parallel multiplicand, captured at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| s_valid_i | input | 1 | Multiplier digit valid |
| s_ready_o | output | 1 | Multiplier digit accepted this cycle if valid |
| s_digit_i | input | DIGIT_W | Multiplier digit, least significant first |
| m_valid_o | output | 1 | Product digit valid |
| m_ready_i | input | 1 | Consumer takes product digit |
| m_digit_o | output | DIGIT_W | Product digit, least significant first |

## Verification
The assertions assume that the multiplicand fits the selected word length, that start_i is a clean synchronous pulse, and that the source holds s_digit_i steady while it waits. They also assume the consumer treats m_digit_o as meaningful only when m_valid_o is high. The stimulus masks every random operand to the active word length before applying it. Between starts it drives s_valid_i and m_ready_i with independent random gaps, so both stall directions occur in every phase. Directed cases add all-ones operands, zero, a mid-operation mode write and a mid-operation start.

// File: rtl/dsmul_pkg.sv
package dsmul_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FEED  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;

  // Word length in bits for a mode code; a 24-bit length needs an 8-bit digit.
  function automatic int unsigned len_bits(input logic [1:0] code, input int unsigned digit_w);
    case (code)
      2'd0:    len_bits = 16;
      2'd1:    len_bits = (digit_w == 8) ? 24 : 32;
      default: len_bits = 32;
    endcase
  endfunction

endpackage

// File: rtl/dsmul_mode_ctrl.sv
module dsmul_mode_ctrl #(
  parameter int DIGIT_W = 8,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             mode_we_i,
  input  logic             busy_i,
  input  logic             finish_i,
  output logic [CNT_W-1:0] digits_o
);
  logic [1:0]       cur_mode;
  logic [1:0]       pend_mode;
  logic             pend_v;
  logic [CNT_W-1:0] dig_tbl [4];

  for (genvar g = 0; g < 4; g++) begin : g_tbl
    assign dig_tbl[g] = CNT_W'(dsmul_pkg::len_bits(2'(g), DIGIT_W) / DIGIT_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode  <= 2'd2;
      pend_mode <= 2'd0;
      pend_v    <= 1'b0;
    end else if (!busy_i) begin
      if (mode_we_i) cur_mode <= mode_i;
    end else if (finish_i) begin
      if (mode_we_i)   cur_mode <= mode_i;
      else if (pend_v) cur_mode <= pend_mode;
      pend_v <= 1'b0;
    end else if (mode_we_i) begin
      pend_mode <= mode_i;
      pend_v    <= 1'b1;
    end
  end

  assign digits_o = dig_tbl[cur_mode];

  // R6: the active length cannot move during a running operation
  a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !finish_i) |=> $stable(cur_mode));

endmodule

// File: rtl/dsmul_seq.sv
module dsmul_seq #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] digits_i,
  input  logic             s_valid_i,
  input  logic             m_ready_i,
  output logic             s_ready_o,
  output logic             m_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             finish_o,
  output logic             load_o,
  output logic             feed_o,
  output logic             step_o
);
  import dsmul_pkg::*;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] k_q;
  logic             last;

  assign busy_o    = (phase != PH_IDLE);
  assign feed_o    = (phase == PH_FEED);
  assign load_o    = start_i && (phase == PH_IDLE);
  assign s_ready_o = feed_o && m_ready_i;
  assign m_valid_o = feed_o ? s_valid_i : (phase == PH_DRAIN);
  assign step_o    = m_valid_o && m_ready_i;
  assign last      = (cnt == k_q - 1'b1);
  assign finish_o  = step_o && last && (phase == PH_DRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      k_q    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish_o;
      if (load_o) begin
        phase <= PH_FEED;
        cnt   <= '0;
        k_q   <= digits_i;
      end else if (step_o) begin
        if (last) begin
          cnt   <= '0;
          phase <= (phase == PH_FEED) ? PH_DRAIN : PH_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9: a start while idle opens an operation
  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R7: completion pulse lasts one cycle and only outside an operation
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R4: digit counter stays inside the latched length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt < k_q));
  // R8: a start during an operation leaves the phase unchanged unless a step ends it
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !step_o) |=> ($stable(cnt) && busy_o));

endmodule

// File: rtl/dsmul_datapath.sv
module dsmul_datapath #(
  parameter int DIGIT_W = 8,
  parameter int MAX_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [MAX_W-1:0]   opa_i,
  input  logic               feed_i,
  input  logic               step_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [DIGIT_W-1:0] digit_o
);
  localparam int SUM_W = MAX_W + DIGIT_W;

  logic [MAX_W-1:0] a_q;
  logic [MAX_W-1:0] acc;
  logic [SUM_W-1:0] pp;
  logic [SUM_W-1:0] sum;

  assign pp      = feed_i ? ({{DIGIT_W{1'b0}}, a_q} * {{MAX_W{1'b0}}, digit_i}) : '0;
  assign sum     = {{DIGIT_W{1'b0}}, acc} + pp;
  assign digit_o = sum[DIGIT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      acc <= '0;
    end else if (load_i) begin
      a_q <= opa_i;
      acc <= '0;
    end else if (step_i) begin
      acc <= sum[SUM_W-1:DIGIT_W];
    end
  end

  // R5: a drain digit that was not taken is offered again unchanged
  a_r5_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!feed_i && !step_i && !load_i) |=> $stable(acc));
  // R9: the multiplicand moves only on a load
  a_r9_opa_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(a_q));

endmodule

// File: rtl/dsmul_top.sv
module dsmul_top #(
  parameter int DIGIT_W = 8,
  parameter int MAX_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               mode_we_i,
  input  logic               start_i,
  input  logic [MAX_W-1:0]   opa_i,
  output logic               busy_o,
  output logic               done_o,
  input  logic               s_valid_i,
  output logic               s_ready_o,
  input  logic [DIGIT_W-1:0] s_digit_i,
  output logic               m_valid_o,
  input  logic               m_ready_i,
  output logic [DIGIT_W-1:0] m_digit_o
);
  localparam int MAX_DIG = MAX_W / DIGIT_W;
  localparam int CNT_W   = $clog2(MAX_DIG + 1);

  logic [CNT_W-1:0] digits;
  logic             finish;
  logic             load;
  logic             feed;
  logic             step;

  dsmul_mode_ctrl #(.DIGIT_W(DIGIT_W), .CNT_W(CNT_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .mode_we_i(mode_we_i),
    .busy_i   (busy_o),
    .finish_i (finish),
    .digits_o (digits)
  );

  dsmul_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .digits_i (digits),
    .s_valid_i(s_valid_i),
    .m_ready_i(m_ready_i),
    .s_ready_o(s_ready_o),
    .m_valid_o(m_valid_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .finish_o (finish),
    .load_o   (load),
    .feed_o   (feed),
    .step_o   (step)
  );

  dsmul_datapath #(.DIGIT_W(DIGIT_W), .MAX_W(MAX_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .opa_i  (opa_i),
    .feed_i (feed),
    .step_i (step),
    .digit_i(s_digit_i),
    .digit_o(m_digit_o)
  );

  // R4: the input stream is closed outside an operation
  a_r4_no_input_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!s_ready_o && !m_valid_o));
  // R5: a drain digit waiting for the consumer stays valid and stable
  a_r5_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i && !s_ready_o && busy_o && !s_valid_i) |=> (m_valid_o && $stable(m_digit_o)) || s_ready_o);

endmodule

// File: tb/tb_dsmul_top.sv
`timescale 1ns/1ps
module tb_dsmul_top;
  localparam int DW = 8;
  localparam int MW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          mode_we = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] opa = '0;
  logic          busy, done;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_digit = '0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [DW-1:0] m_digit;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dsmul_top #(.DIGIT_W(DW), .MAX_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .mode_we_i(mode_we),
    .start_i(start), .opa_i(opa), .busy_o(busy), .done_o(done),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_digit_i(s_digit),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_digit_o(m_digit)
  );

  function automatic int exp_bits(input logic [1:0] m);
    if (m == 2'd0) return 16;
    if (m == 2'd1) return (DW == 8) ? 24 : 32;
    return 32;
  endfunction

  function automatic logic [63:0] mask_w(input logic [63:0] v, input int w);
    return v & ((64'd1 << w) - 64'd1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m; mode_we = 1'b1;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // Runs one product; poke adds a mode write and a start while busy.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int w,
                        input bit poke, input logic [1:0] poke_mode);
    int k, ii, oc, cyc;
    bit bad4, bad5, hold_v;
    logic [DW-1:0] hold_d;
    logic [63:0] got, exp;
    k = w / DW; ii = 0; oc = 0; cyc = 0;
    bad4 = 0; bad5 = 0; hold_v = 0; hold_d = '0; got = '0;
    exp = 64'(a) * 64'(b);
    @(negedge clk);
    start = 1'b1; opa = a;
    @(negedge clk);
    start = 1'b0; opa = $urandom;
    check(busy === 1'b1, "R9 busy after start", 64'(busy), 64'd1);
    while (oc < 2 * k && cyc < 2000) begin
      s_valid = (ii < k) && ($urandom % 4 != 0);
      s_digit = (ii < k) ? b[ii*DW +: DW] : DW'($urandom);
      m_ready = ($urandom % 4 != 0);
      start   = poke && (cyc == 1);
      mode_we = poke && (cyc == 1);
      mode    = poke_mode;
      #1;
      if (hold_v && m_digit !== hold_d) bad5 = 1;
      if (oc < k && (s_ready !== m_ready || m_valid !== s_valid)) bad5 = 1;
      if (oc >= k && (s_ready !== 1'b0 || m_valid !== 1'b1)) bad4 = bad4 | (s_ready !== 1'b0);
      if (oc >= k && m_valid !== 1'b1) bad5 = 1;
      hold_v = (oc >= k) && m_valid && !m_ready;
      hold_d = m_digit;
      if (s_valid && s_ready) ii++;
      if (m_valid && m_ready) begin
        got[oc*DW +: DW] = m_digit;
        oc++;
      end
      cyc++;
      @(negedge clk);
      start = 1'b0; mode_we = 1'b0;
    end
    s_valid = 1'b0; m_ready = 1'b0;
    check(cyc < 2000, "R2 operation completes", 64'(cyc), 64'd0);
    check(got === exp, "R2 product", got, exp);
    check(ii == k && !bad4, "R4 input digit count", 64'(ii), 64'(k));
    check(!bad5, "R5 stream handshake", 64'(bad5), 64'd0);
    check(done === 1'b1 && busy === 1'b0, "R3 R7 done after last digit", {62'd0, done, busy}, 64'b10);
    @(negedge clk);
    check(done === 1'b0, "R7 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    int w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && !m_valid && !s_ready, "R1 reset state",
          {60'd0, busy, done, m_valid, s_ready}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners for every code (R3)
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      w = exp_bits(2'(m));
      run_op(32'(mask_w(64'hFFFF_FFFF, w)), 32'(mask_w(64'hFFFF_FFFF, w)), w, 0, 2'd0);
      run_op(32'd0, 32'(mask_w(64'h1234_5678, w)), w, 0, 2'd0);
      run_op(32'd1, 32'(mask_w(64'h8000_0001, w)), w, 0, 2'd0);
    end

    // R6, R8: mode write and start while busy; running length unchanged
    set_mode(2'd0);
    run_op(32'h0000_BEEF, 32'h0000_F00D, 16, 1, 2'd2);
    run_op(32'hCAFE_1234, 32'h89AB_CDEF, 32, 0, 2'd0);
    set_mode(2'd1);
    run_op(32'h00AB_CDEF, 32'h00FE_DCBA, 24, 0, 2'd0);

    // Random operands per mode (R2)
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      w = exp_bits(2'(m));
      for (int i = 0; i < 12; i++) begin
        ra = 32'(mask_w(64'($urandom), w));
        rb = 32'(mask_w(64'($urandom), w));
        run_op(ra, rb, w, 0, 2'd0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule